// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block governs the transaction flow of a single DMA channel. It watches one line, chosen by a select input, out of a vector of interrupt request lines. Each time that line is high while the channel is armed, the block issues bus transfer requests to the address generator and bus. Depending on the programmed mode, it issues either one request or a counted burst of back-to-back requests. It counts accepted transfers against a programmed count. When the count runs out it raises a one-cycle completion interrupt and, if configured, a reload strobe that tells the address generator to restore its start addresses.

The block has four modes. In the single mode, each trigger moves one item. In the burst mode, each trigger moves the whole count. Each of these two also has a repeating variant, which stays armed after completion and reloads automatically. The non-repeating variants disarm at completion and reload only when asked to. The address generator can flag an address-limit violation during a request. That flag aborts the transaction, raises an error interrupt and disarms the channel. The completion interrupt may be wired to another channel's trigger lines, which cascades the two channels.

Top module: `dma_xfer_seq`

## Requirements
- R1: A trigger is any clock cycle in which `trig_lines[trig_sel]` is 1. Every other line has no effect. A `trig_sel` value of `NUM_TRIG` or above never triggers.
- R2: After reset, all outputs are 0 and the channel is disarmed. A 0-to-1 change of `chan_en` arms the channel and loads the count, with a programmed count of 0 treated as 1. While `chan_en` is 0, triggers are ignored, and `xfer_req` is 0 from the cycle after `chan_en` falls.
- R3: With `xfer_mode`=00 (single), each trigger yields one transfer. The N-th transfer completes the transaction and disarms the channel. Further triggers are ignored until `chan_en` rises again.
- R4: With `xfer_mode`=01 (burst), one trigger yields N transfers, with exactly one idle cycle between consecutive requests. Completion then disarms the channel.
- R5: With `xfer_mode`=10 (repeating single), each trigger yields one transfer and the channel stays armed. Every N-th transfer raises `done_irq` together with `reload_stb` and restores the count.
- R6: With `xfer_mode`=11 (repeating burst), each trigger yields a full burst of N transfers. Each burst ends with `done_irq` and `reload_stb`, and the channel stays armed.
- R7: In modes 00 and 01, `reload_stb` accompanies `done_irq` only when `reload_en` is 1. `reload_stb` is never high without `done_irq`.
- R8: `xfer_req` rises in the cycle after the trigger cycle. It holds until `bus_done` or `limit_err` is seen, and it is 0 in the cycle after that handshake.
- R9: Triggers arriving while a request or burst is in progress are remembered as one pending trigger, not counted. That pending trigger starts the next request or burst once the current one ends, provided the channel is still armed.
- R10: `limit_err` high while `xfer_req` is high aborts the transaction. `err_irq` pulses one cycle later, no `done_irq` or `reload_stb` is produced, and the channel disarms.
- R11: `done_irq` is a one-cycle pulse in the cycle after the `bus_done` that accepts the last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; a rising edge arms and loads the count |
| xfer_mode | input | 2 | Bit 0 selects burst, bit 1 selects repeating |
| trig_sel | input | clog2(NUM_TRIG) | Index of the trigger line to watch |
| trig_lines | input | NUM_TRIG | Interrupt request lines |
| xfer_count | input | CNT_W | Transfers per transaction |
| reload_en | input | 1 | Reload after completion in non-repeating modes |
| bus_done | input | 1 | Bus accepted the current transfer |
| limit_err | input | 1 | Address-limit violation on the current transfer |
| xfer_req | output | 1 | Transfer request to address generator and bus |
| reload_stb | output | 1 | One-cycle reload strobe for addresses |
| done_irq | output | 1 | One-cycle completion interrupt |
| err_irq | output | 1 | One-cycle abort interrupt |

## Verification
The bench builds the block with six trigger lines and an 8-bit count. A 3-bit select can then reach two values that match no line, and every select/line pair can be swept. It also sweeps all four modes against counts of 1 to 3, with reload enabled and disabled. The small counts keep every completion, reload and re-arm boundary within a few dozen cycles. Expected transfer, done and reload totals are derived arithmetically from the trigger count and N. Burst timing is checked against the closed form N·(L+2)−1 for bus latency L.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        XM_SINGLE     = 2'b00,
        XM_BURST      = 2'b01,
        XM_SINGLE_RPT = 2'b10,
        XM_BURST_RPT  = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_GAP  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       armed;
        logic       pending;
        seq_state_e st;
    } seq_ctx_t;

    localparam seq_ctx_t CTX_RESET = '{armed: 1'b0, pending: 1'b0, st: SQ_IDLE};

    function automatic logic mode_repeats(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic mode_bursts(input logic [1:0] m);
        return m[0];
    endfunction

    function automatic logic reload_wanted(input logic [1:0] m, input logic rl);
        return m[1] | rl;
    endfunction

endpackage

// File: rtl/dma_trig_select.sv
module dma_trig_select #(
    parameter int NUM_TRIG = 60,
    parameter int SEL_W    = 6
) (
    input  logic [NUM_TRIG-1:0] trig_lines,
    input  logic [SEL_W-1:0]    trig_sel,
    output logic                trig_hit
);
    always_comb begin
        trig_hit = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (trig_sel == SEL_W'(i)) trig_hit = trig_lines[i];
        end
    end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] count_in,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] load_val;

    assign load_val = (count_in == '0) ? ONE : count_in;

    always_ff @(posedge clk) begin
        if (rst)                         remain <= '0;
        else if (load)                   remain <= load_val;
        else if (dec && remain != '0)    remain <= remain - ONE;
    end

    assign last = (remain == ONE);
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_en,
    input  logic [1:0] xfer_mode,
    input  logic       reload_en,
    input  logic       trig_hit,
    input  logic       bus_done,
    input  logic       limit_err,
    input  logic       cnt_last,
    output logic       cnt_load,
    output logic       cnt_dec,
    output logic       xfer_req,
    output logic       done_irq,
    output logic       err_irq,
    output logic       reload_stb
);
    seq_ctx_t ctx, ctx_nx;
    logic     en_q;
    logic     arm_evt, accept, abort, complete, rl_act;

    assign arm_evt  = chan_en & ~en_q;
    assign accept   = chan_en & (ctx.st == SQ_REQ) & bus_done & ~limit_err;
    assign abort    = chan_en & (ctx.st == SQ_REQ) & limit_err;
    assign complete = accept & cnt_last;
    assign rl_act   = reload_wanted(xfer_mode, reload_en);

    assign cnt_load = arm_evt | (complete & rl_act);
    assign cnt_dec  = accept;
    assign xfer_req = (ctx.st == SQ_REQ);

    always_comb begin
        ctx_nx = ctx;
        if (!chan_en) begin
            ctx_nx = CTX_RESET;
        end else begin
            if (arm_evt) ctx_nx.armed = 1'b1;
            unique case (ctx.st)
                SQ_IDLE: begin
                    if (ctx.armed && (trig_hit || ctx.pending)) begin
                        ctx_nx.st      = SQ_REQ;
                        ctx_nx.pending = 1'b0;
                    end
                end
                SQ_REQ: begin
                    if (trig_hit) ctx_nx.pending = 1'b1;
                    if (abort) begin
                        ctx_nx = CTX_RESET;
                    end else if (accept) begin
                        if (complete) begin
                            ctx_nx.st = SQ_IDLE;
                            if (!mode_repeats(xfer_mode)) begin
                                ctx_nx.armed   = 1'b0;
                                ctx_nx.pending = 1'b0;
                            end
                        end else if (mode_bursts(xfer_mode)) begin
                            ctx_nx.st = SQ_GAP;
                        end else begin
                            ctx_nx.st = SQ_IDLE;
                        end
                    end
                end
                SQ_GAP: begin
                    if (trig_hit) ctx_nx.pending = 1'b1;
                    ctx_nx.st = SQ_REQ;
                end
                default: ctx_nx = CTX_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx        <= CTX_RESET;
            en_q       <= 1'b0;
            done_irq   <= 1'b0;
            err_irq    <= 1'b0;
            reload_stb <= 1'b0;
        end else begin
            ctx        <= ctx_nx;
            en_q       <= chan_en;
            done_irq   <= complete;
            err_irq    <= abort;
            reload_stb <= complete & rl_act;
        end
    end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
    parameter int NUM_TRIG = 60,
    parameter int CNT_W    = 16,
    localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chan_en,
    input  logic [1:0]          xfer_mode,
    input  logic [SEL_W-1:0]    trig_sel,
    input  logic [NUM_TRIG-1:0] trig_lines,
    input  logic [CNT_W-1:0]    xfer_count,
    input  logic                reload_en,
    input  logic                bus_done,
    input  logic                limit_err,
    output logic                xfer_req,
    output logic                reload_stb,
    output logic                done_irq,
    output logic                err_irq
);
    logic trig_hit, cnt_load, cnt_dec, cnt_last;

    dma_trig_select #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) sel_i (
        .trig_lines(trig_lines),
        .trig_sel  (trig_sel),
        .trig_hit  (trig_hit)
    );

    dma_xfer_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .load    (cnt_load),
        .dec     (cnt_dec),
        .count_in(xfer_count),
        .last    (cnt_last)
    );

    dma_seq_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .chan_en   (chan_en),
        .xfer_mode (xfer_mode),
        .reload_en (reload_en),
        .trig_hit  (trig_hit),
        .bus_done  (bus_done),
        .limit_err (limit_err),
        .cnt_last  (cnt_last),
        .cnt_load  (cnt_load),
        .cnt_dec   (cnt_dec),
        .xfer_req  (xfer_req),
        .done_irq  (done_irq),
        .err_irq   (err_irq),
        .reload_stb(reload_stb)
    );
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       chan_en,
    input logic [1:0] xfer_mode,
    input logic       bus_done,
    input logic       limit_err,
    input logic       xfer_req,
    input logic       reload_stb,
    input logic       done_irq,
    input logic       err_irq
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !bus_done && !limit_err && chan_en) |=> xfer_req);

    assert_req_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && (bus_done || limit_err)) |=> !xfer_req);

    assert_disable_R2: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !xfer_req);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);

    assert_done_source_R11: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> $past(xfer_req && bus_done && !limit_err));

    assert_err_source_R10: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> $past(xfer_req && limit_err));

    assert_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(err_irq && (done_irq || reload_stb)));

    assert_reload_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        reload_stb |-> done_irq);

    assert_repeat_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (done_irq && $past(xfer_mode[1])) |-> reload_stb);
endmodule

bind dma_xfer_seq dma_xfer_seq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .chan_en   (chan_en),
    .xfer_mode (xfer_mode),
    .bus_done  (bus_done),
    .limit_err (limit_err),
    .xfer_req  (xfer_req),
    .reload_stb(reload_stb),
    .done_irq  (done_irq),
    .err_irq   (err_irq)
);

// File: tb/dma_xfer_seq_tb.sv
module dma_xfer_seq_tb_top;
    localparam int NT = 6;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chan_en = 1'b0;
    logic [1:0]    xfer_mode = 2'b00;
    logic [2:0]    trig_sel = 3'd0;
    logic [NT-1:0] trig_lines = '0;
    logic [CW-1:0] xfer_count = '0;
    logic          reload_en = 1'b0;
    logic          bus_done = 1'b0;
    logic          limit_err = 1'b0;
    logic          xfer_req, reload_stb, done_irq, err_irq;

    int checks = 0, errors = 0;
    int n_xfer = 0, n_done = 0, n_err = 0, n_rel = 0, n_rise = 0;
    int lat = 0, abort_idx = -1, wait_cnt = 0;
    logic req_q = 1'b0;

    always #5 clk = ~clk;

    dma_xfer_seq #(.NUM_TRIG(NT), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .chan_en(chan_en), .xfer_mode(xfer_mode),
        .trig_sel(trig_sel), .trig_lines(trig_lines), .xfer_count(xfer_count),
        .reload_en(reload_en), .bus_done(bus_done), .limit_err(limit_err),
        .xfer_req(xfer_req), .reload_stb(reload_stb), .done_irq(done_irq),
        .err_irq(err_irq)
    );

    // bus responder: answers after lat cycles, or flags a limit violation
    always @(negedge clk) begin
        if (xfer_req && !bus_done && !limit_err) begin
            if (wait_cnt >= lat) begin
                wait_cnt = 0;
                if (n_xfer == abort_idx) limit_err = 1'b1;
                else begin bus_done = 1'b1; n_xfer++; end
            end else wait_cnt++;
        end else begin
            bus_done  = 1'b0;
            limit_err = 1'b0;
            if (!xfer_req) wait_cnt = 0;
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (done_irq)   n_done++;
        if (err_irq)    n_err++;
        if (reload_stb) n_rel++;
        if (xfer_req && !req_q) n_rise++;
        req_q = xfer_req;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr;
        n_xfer = 0; n_done = 0; n_err = 0; n_rel = 0; n_rise = 0;
    endtask

    task automatic enable_ch(input int m, input int cnt, input int rl);
        chan_en = 1'b0;
        xfer_mode = 2'(m);
        xfer_count = CW'(cnt);
        reload_en = rl[0];
        tick(1);
        chan_en = 1'b1;
        tick(2);
    endtask

    task automatic pulse(input int line);
        trig_lines = '0;
        trig_lines[line] = 1'b1;
        tick(1);
        trig_lines = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R2 reset state
        chk("R2 reset xfer_req", int'(xfer_req), 0);
        chk("R2 reset done_irq", int'(done_irq), 0);
        chk("R2 reset err_irq", int'(err_irq), 0);
        chk("R2 reset reload_stb", int'(reload_stb), 0);

        // R1 trigger select sweep, repeating single mode with a large count
        enable_ch(2, 200, 0);
        lat = 0;
        for (int s = 0; s < 8; s++) begin
            for (int l = 0; l < NT; l++) begin
                clr();
                trig_sel = 3'(s);
                pulse(l);
                tick(4);
                chk($sformatf("R1 sel %0d line %0d", s, l), n_xfer, (s == l) ? 1 : 0);
            end
        end
        trig_sel = 3'd0;

        // R3..R7 mode x count x reload sweep
        lat = 1;
        for (int m = 0; m < 4; m++) begin
            for (int n = 1; n <= 3; n++) begin
                for (int rl = 0; rl < 2; rl++) begin
                    int t, ex, ed, er;
                    string tag;
                    tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
                    enable_ch(m, n, rl);
                    clr();
                    if (m[0] == 1'b0) begin
                        t = 2 * n + 1;
                        for (int k = 0; k < t; k++) begin pulse(0); tick(6); end
                        ex = (m == 0) ? n : t;
                        ed = (m == 0) ? 1 : t / n;
                    end else begin
                        t = 3;
                        for (int k = 0; k < t; k++) begin pulse(0); tick(4 * n + 8); end
                        ex = (m == 1) ? n : 3 * n;
                        ed = (m == 1) ? 1 : 3;
                    end
                    er = (m >= 2) ? ed : rl;
                    chk($sformatf("%s xfers m%0d n%0d rl%0d", tag, m, n, rl), n_xfer, ex);
                    chk($sformatf("%s dones m%0d n%0d rl%0d", tag, m, n, rl), n_done, ed);
                    chk($sformatf("%s reloads m%0d n%0d rl%0d", (m < 2) ? "R7" : tag, m, n, rl), n_rel, er);
                    if (m == 0) begin
                        // R3 re-enable re-arms after completion
                        enable_ch(m, n, rl);
                        clr();
                        pulse(0); tick(6);
                        chk("R3 re-arm after enable", n_xfer, 1);
                    end
                end
            end
        end

        // R8 request rises the cycle after the trigger
        enable_ch(2, 200, 0);
        lat = 0;
        pulse(0);
        chk("R8 request after trigger", int'(xfer_req), 1);
        tick(4);

        // R4 R8 R11 burst timing: done at N*(L+2)-1 negedges after the trigger
        begin
            int found;
            found = -1;
            enable_ch(1, 3, 0);
            lat = 2;
            clr();
            pulse(0);
            for (int i = 1; i <= 40; i++) begin
                tick(1);
                if (done_irq && found < 0) found = i;
            end
            chk("R11 done timing", found, 3 * (2 + 2) - 1);
            chk("R4 separate requests", n_rise, 3);
            chk("R11 single done", n_done, 1);
        end

        // R9 pending collapse, repeating single
        enable_ch(2, 10, 0);
        lat = 5;
        clr();
        trig_lines[0] = 1'b1; tick(3); trig_lines = '0;
        tick(25);
        chk("R9 single pending single", n_xfer, 2);

        // R9 pending collapse, repeating burst
        enable_ch(3, 3, 0);
        lat = 0;
        clr();
        pulse(0); tick(1); pulse(0); pulse(0);
        tick(30);
        chk("R9 pending burst xfers", n_xfer, 6);
        chk("R9 pending burst dones", n_done, 2);

        // R10 abort on limit violation
        enable_ch(3, 4, 0);
        lat = 0;
        abort_idx = 1;
        clr();
        pulse(0); tick(20);
        chk("R10 xfers before abort", n_xfer, 1);
        chk("R10 err pulses", n_err, 1);
        chk("R10 no done", n_done, 0);
        chk("R10 no reload", n_rel, 0);
        abort_idx = -1;
        pulse(0); tick(10);
        chk("R10 disarmed after abort", n_xfer, 1);

        // R2 disable mid-transfer, then triggers ignored
        enable_ch(1, 5, 0);
        lat = 10;
        clr();
        pulse(0); tick(2);
        chan_en = 1'b0;
        tick(1);
        chk("R2 req drops on disable", int'(xfer_req), 0);
        pulse(0); tick(15);
        chk("R2 disabled ignores trigger", n_xfer, 0);
        chk("R2 disabled no done", n_done, 0);

        // R2 zero count treated as one
        enable_ch(0, 0, 0);
        lat = 0;
        clr();
        pulse(0); tick(6);
        chk("R2 zero count xfers", n_xfer, 1);
        chk("R2 zero count done", n_done, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule